// File: doc/BRIEF.md
# Deep Sleep Power Mode Controller

This controller sits beside a CPU and decides which of three power states the subsystem is in: running, ordinary sleep or deep sleep. When the CPU issues its sleep strobe, the controller looks at a deep-select bit in its sleep control register. If the bit is set, the subsystem enters deep sleep. If it is clear, the subsystem enters ordinary sleep. In both sleep states the CPU is held halted without any reset, so its register contents survive. Deep sleep goes further than ordinary sleep. It also stops the DMA engine and blocks every external bus access, auto-refresh included. The external clock output keeps running in deep sleep.

Two module-stop registers supply one clock-stop bit per peripheral. These bits are honoured in every power state. A two-bit status output tells the three states apart. An unmasked interrupt or a wake reset input returns the subsystem to running, and every sleep restriction lifts on the same clock edge. Before the bus inhibit takes effect, the memory side must acknowledge self-refresh. If deep sleep is entered while refresh is still needed and no acknowledge has come, a sticky error flag records it. All registers are written through a plain write port.

Top module: `dslp_ctrl`

## Requirements
- R1: A sleep strobe in the running state moves status to 10 (deep) on the next cycle when control bit 0 (address 0) is 1, and to 01 (ordinary sleep) when it is 0. The bit value used is the one held before any write in the same cycle.
- R2: cpu_halt is high in both sleep states and low while running. No register content is lost across a sleep and wake sequence.
- R3: dma_stop is high in deep sleep only. It is low in ordinary sleep and while running.
- R4: bus_inhibit is high only in deep sleep, and only while sref_ack is 1 or refresh_req is 0.
- R5: ckout_en is high while running and in deep sleep. It is also high in ordinary sleep unless the option CKO_GATE_IN_SLEEP is 1.
- R6: status reads 00 while running, 01 in ordinary sleep and 10 in deep sleep. It never reads 11.
- R7: mod_clk_en[32*k+j] equals the inverse of bit j of module-stop word k in every power state. Word 0 is written at address 1 and word 1 at address 2.
- R8: A sleep strobe is ignored while sleeping, and wake inputs are ignored while running.
- R9: wake_irq or wake_rst in either sleep state returns status to 00 on the next cycle. cpu_halt, dma_stop and bus_inhibit all drop on that same edge.
- R10: sref_err is set on the cycle after one in which the subsystem is in deep sleep with refresh_req=1 and sref_ack=0. It stays set until a write to address 0 with data bit 1 = 1; a set condition in the same cycle as such a write wins.
- R11: rst_n low clears every register to zero. The subsystem then reads status 00, all mod_clk_en bits 1 and sref_err 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 and 2 module-stop words) |
| wr_data | input | 32 | Register write data |
| sleep_strobe | input | 1 | Sleep request pulse from the CPU |
| wake_irq | input | 1 | Unmasked interrupt pending |
| wake_rst | input | 1 | Wake reset request |
| refresh_req | input | 1 | Memory still needs refresh |
| sref_ack | input | 1 | Memory has entered self-refresh |
| cpu_halt | output | 1 | Halts the CPU without reset |
| dma_stop | output | 1 | Stops the DMA engine |
| bus_inhibit | output | 1 | Blocks all external bus access, refresh included |
| mod_clk_en | output | 64 | Per-module clock enables |
| ckout_en | output | 1 | External clock output enable |
| status | output | 2 | Power state code |
| sref_err | output | 1 | Sticky missing self-refresh acknowledge flag |

## Verification
Sleep entry is swept over every combination of deep-select bit, wake source, refresh request and self-refresh acknowledge. This separates the two sleep paths, the gating of the bus inhibit and the error flag, and it shows that wakes by interrupt and by reset behave alike. A walking one across all 64 module-stop bits exposes any swapped or stuck clock enable. Directed cases cover a strobe arriving together with a control write, repeated strobes while asleep, wake inputs while running, and a reset taken from deep sleep.

// File: rtl/dslp_pkg.sv
package dslp_pkg;
   typedef enum logic [1:0] {
      PS_RUN   = 2'b00,
      PS_SLEEP = 2'b01,
      PS_DEEP  = 2'b10
   } pstate_e;

   localparam int unsigned CTL_ADDR     = 0;
   localparam int unsigned CTL_DEEP_BIT = 0;
   localparam int unsigned CTL_ECLR_BIT = 1;
endpackage

// File: rtl/dslp_regfile.sv
module dslp_regfile #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_STOP = 2,
   parameter int unsigned ADDR_W   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   output logic                         deep_sel,
   output logic                         err_clr,
   output logic [NUM_STOP*DATA_W-1:0]   mstop
);
   import dslp_pkg::*;

   localparam int unsigned NUM_REGS = NUM_STOP + 1;

   initial begin
      if (NUM_REGS > (1 << ADDR_W))
         $fatal(1, "dslp_regfile: address width too small for register count");
      if (DATA_W < 2)
         $fatal(1, "dslp_regfile: data width must hold the control bits");
   end

   logic ctl_hit;
   assign ctl_hit = wr_en && (wr_addr == ADDR_W'(CTL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         deep_sel <= 1'b0;
      else if (ctl_hit)
         deep_sel <= wr_data[CTL_DEEP_BIT];
   end

   assign err_clr = ctl_hit && wr_data[CTL_ECLR_BIT];

   for (genvar k = 0; k < NUM_STOP; k++) begin : g_stop
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(k + 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mstop[k*DATA_W +: DATA_W] <= '0;
         else if (hit)
            mstop[k*DATA_W +: DATA_W] <= wr_data;
      end
   end
endmodule

// File: rtl/dslp_fsm.sv
module dslp_fsm (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_strobe,
   input  logic               deep_sel,
   input  logic               wake_irq,
   input  logic               wake_rst,
   output dslp_pkg::pstate_e  state
);
   import dslp_pkg::*;

   pstate_e state_q, state_d;
   logic    wake;

   assign wake = wake_irq || wake_rst;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PS_RUN: begin
            if (sleep_strobe)
               state_d = deep_sel ? PS_DEEP : PS_SLEEP;
         end
         PS_SLEEP, PS_DEEP: begin
            if (wake)
               state_d = PS_RUN;
         end
         default: state_d = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= PS_RUN;
      else
         state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/dslp_outdec.sv
module dslp_outdec #(
   parameter int unsigned NUM_MOD           = 64,
   parameter bit          CKO_GATE_IN_SLEEP = 1'b0
) (
   input  dslp_pkg::pstate_e  state,
   input  logic [NUM_MOD-1:0] mstop,
   input  logic               refresh_req,
   input  logic               sref_ack,
   output logic               cpu_halt,
   output logic               dma_stop,
   output logic               bus_inhibit,
   output logic [NUM_MOD-1:0] mod_clk_en,
   output logic               ckout_en,
   output logic [1:0]         status
);
   import dslp_pkg::*;

   logic in_deep, in_sleep, refresh_safe;

   assign in_deep      = (state == PS_DEEP);
   assign in_sleep     = (state == PS_SLEEP);
   assign refresh_safe = sref_ack || !refresh_req;

   assign cpu_halt    = in_deep || in_sleep;
   assign dma_stop    = in_deep;
   assign bus_inhibit = in_deep && refresh_safe;
   assign status      = {in_deep, in_sleep};

   for (genvar i = 0; i < NUM_MOD; i++) begin : g_mclk
      assign mod_clk_en[i] = !mstop[i];
   end

   if (CKO_GATE_IN_SLEEP) begin : g_cko_gated
      assign ckout_en = !in_sleep;
   end else begin : g_cko_free
      assign ckout_en = 1'b1;
   end
endmodule

// File: rtl/dslp_errflag.sv
module dslp_errflag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_cond,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (set_cond)
         flag <= 1'b1;
      else if (clr)
         flag <= 1'b0;
   end
endmodule

// File: rtl/dslp_ctrl.sv
module dslp_ctrl #(
   parameter int unsigned DATA_W            = 32,
   parameter int unsigned NUM_STOP          = 2,
   parameter int unsigned ADDR_W            = 2,
   parameter bit          CKO_GATE_IN_SLEEP = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       sleep_strobe,
   input  logic                       wake_irq,
   input  logic                       wake_rst,
   input  logic                       refresh_req,
   input  logic                       sref_ack,
   output logic                       cpu_halt,
   output logic                       dma_stop,
   output logic                       bus_inhibit,
   output logic [NUM_STOP*DATA_W-1:0] mod_clk_en,
   output logic                       ckout_en,
   output logic [1:0]                 status,
   output logic                       sref_err
);
   import dslp_pkg::*;

   localparam int unsigned NUM_MOD = NUM_STOP * DATA_W;

   logic               deep_sel;
   logic               err_clr;
   logic [NUM_MOD-1:0] mstop;
   pstate_e            state;
   logic               err_set;

   dslp_regfile #(
      .DATA_W  (DATA_W),
      .NUM_STOP(NUM_STOP),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .deep_sel(deep_sel),
      .err_clr (err_clr),
      .mstop   (mstop)
   );

   dslp_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_strobe(sleep_strobe),
      .deep_sel    (deep_sel),
      .wake_irq    (wake_irq),
      .wake_rst    (wake_rst),
      .state       (state)
   );

   dslp_outdec #(
      .NUM_MOD          (NUM_MOD),
      .CKO_GATE_IN_SLEEP(CKO_GATE_IN_SLEEP)
   ) u_dec (
      .state      (state),
      .mstop      (mstop),
      .refresh_req(refresh_req),
      .sref_ack   (sref_ack),
      .cpu_halt   (cpu_halt),
      .dma_stop   (dma_stop),
      .bus_inhibit(bus_inhibit),
      .mod_clk_en (mod_clk_en),
      .ckout_en   (ckout_en),
      .status     (status)
   );

   assign err_set = (state == PS_DEEP) && refresh_req && !sref_ack;

   dslp_errflag u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_cond(err_set),
      .clr     (err_clr),
      .flag    (sref_err)
   );
endmodule

// File: rtl/dslp_ctrl_chk.sv
module dslp_ctrl_chk #(
   parameter int unsigned DATA_W            = 32,
   parameter int unsigned NUM_STOP          = 2,
   parameter int unsigned ADDR_W            = 2,
   parameter bit          CKO_GATE_IN_SLEEP = 1'b0
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [DATA_W-1:0]          wr_data,
   input logic                       sleep_strobe,
   input logic                       wake_irq,
   input logic                       wake_rst,
   input logic                       refresh_req,
   input logic                       sref_ack,
   input logic                       deep_sel,
   input logic                       cpu_halt,
   input logic                       dma_stop,
   input logic                       bus_inhibit,
   input logic [NUM_STOP*DATA_W-1:0] mod_clk_en,
   input logic                       ckout_en,
   input logic [1:0]                 status,
   input logic                       sref_err
);
   AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b00 && sleep_strobe) |=> (status == {$past(deep_sel), !$past(deep_sel)})); // R1

   AST_HALT_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halt == (status != 2'b00)); // R2

   AST_DMA_DEEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      dma_stop == (status == 2'b10)); // R3

   AST_BUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_inhibit |-> (status == 2'b10 && (sref_ack || !refresh_req))); // R4

   AST_CKO_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 2'b01 || !CKO_GATE_IN_SLEEP) |-> ckout_en); // R5

   AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      status != 2'b11); // R6

   AST_STOP_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && wr_en && wr_addr == ADDR_W'(1)) |-> (mod_clk_en[DATA_W-1:0] == ~$past(wr_data))); // R7

   AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b00 && !sleep_strobe) |=> status == 2'b00); // R8

   AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 2'b00 && !wake_irq && !wake_rst) |=> $stable(status)); // R8

   AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 2'b00 && (wake_irq || wake_rst)) |=> (status == 2'b00 && !cpu_halt && !dma_stop && !bus_inhibit)); // R9

   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b10 && refresh_req && !sref_ack) |=> sref_err); // R10
endmodule

bind dslp_ctrl dslp_ctrl_chk #(
   .DATA_W           (DATA_W),
   .NUM_STOP         (NUM_STOP),
   .ADDR_W           (ADDR_W),
   .CKO_GATE_IN_SLEEP(CKO_GATE_IN_SLEEP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .sleep_strobe(sleep_strobe),
   .wake_irq    (wake_irq),
   .wake_rst    (wake_rst),
   .refresh_req (refresh_req),
   .sref_ack    (sref_ack),
   .deep_sel    (deep_sel),
   .cpu_halt    (cpu_halt),
   .dma_stop    (dma_stop),
   .bus_inhibit (bus_inhibit),
   .mod_clk_en  (mod_clk_en),
   .ckout_en    (ckout_en),
   .status      (status),
   .sref_err    (sref_err)
);

// File: tb/dslp_ctrl_bench.sv
module dslp_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        sleep_strobe = 1'b0;
   logic        wake_irq = 1'b0;
   logic        wake_rst = 1'b0;
   logic        refresh_req = 1'b0;
   logic        sref_ack = 1'b0;
   logic        cpu_halt, dma_stop, bus_inhibit, ckout_en, sref_err;
   logic [63:0] mod_clk_en;
   logic [1:0]  status;

   int vectors = 0;
   int errors  = 0;

   always #5 clk = ~clk;

   dslp_ctrl u_dslp_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sleep_strobe(sleep_strobe), .wake_irq(wake_irq), .wake_rst(wake_rst),
      .refresh_req(refresh_req), .sref_ack(sref_ack), .cpu_halt(cpu_halt),
      .dma_stop(dma_stop), .bus_inhibit(bus_inhibit), .mod_clk_en(mod_clk_en),
      .ckout_en(ckout_en), .status(status), .sref_err(sref_err)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, one posedge passes, return at the following negedge
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic check_run(input string req);
      chk({req, " status"}, 64'(status), 64'(2'b00));
      chk({req, " halt"},   64'(cpu_halt), 64'(0));
      chk({req, " dma"},    64'(dma_stop), 64'(0));
      chk({req, " bus"},    64'(bus_inhibit), 64'(0));
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [63:0] pat;
      tick(); tick();
      // R11 reset state
      chk("R11 status", 64'(status), 64'(0));
      chk("R11 modclk", mod_clk_en, '1);
      chk("R11 err", 64'(sref_err), 64'(0));
      chk("R5 ckout run", 64'(ckout_en), 64'(1));
      rst_n = 1'b1;
      tick();
      check_run("R11");

      // R7 walking one over both stop words
      for (int j = 0; j < 64; j++) begin
         pat = 64'd1 << j;
         wr(2'd1, pat[31:0]);
         wr(2'd2, pat[63:32]);
         chk("R7 walk", mod_clk_en, ~pat);
      end
      wr(2'd1, '0); wr(2'd2, '0);

      // sweep: deep select x wake source x refresh_req x sref_ack
      for (int dp = 0; dp < 2; dp++)
      for (int ws = 0; ws < 2; ws++)
      for (int rr = 0; rr < 2; rr++)
      for (int ak = 0; ak < 2; ak++) begin
         logic [31:0] p0, p1;
         p0 = 32'h0F0F_0000 ^ (32'(dp * 8 + ws * 4 + rr * 2 + ak) * 32'h1111_1111);
         p1 = ~p0;
         wr(2'd0, 32'(dp));
         wr(2'd1, p0);
         wr(2'd2, p1);
         refresh_req = rr[0]; sref_ack = ak[0];
         sleep_strobe = 1'b1;
         tick();
         sleep_strobe = 1'b0;
         chk("R1 R6 status", 64'(status), dp ? 64'(2'b10) : 64'(2'b01));
         chk("R2 halt", 64'(cpu_halt), 64'(1));
         chk("R3 dma", 64'(dma_stop), 64'(dp));
         chk("R4 bus", 64'(bus_inhibit), 64'(dp != 0 && (ak != 0 || rr == 0)));
         chk("R5 ckout", 64'(ckout_en), 64'(1));
         chk("R7 modclk asleep", mod_clk_en, ~{p1, p0});
         // strobe again while asleep: ignored
         sleep_strobe = 1'b1;
         tick();
         sleep_strobe = 1'b0;
         chk("R8 strobe asleep", 64'(status), dp ? 64'(2'b10) : 64'(2'b01));
         chk("R10 err set", 64'(sref_err), 64'(dp != 0 && rr != 0 && ak == 0));
         refresh_req = 1'b0; sref_ack = 1'b0;
         if (ws != 0) wake_rst = 1'b1; else wake_irq = 1'b1;
         tick();
         wake_rst = 1'b0; wake_irq = 1'b0;
         check_run("R9 wake");
         chk("R2 regs kept", mod_clk_en, ~{p1, p0});
         chk("R10 err sticky", 64'(sref_err), 64'(dp != 0 && rr != 0 && ak == 0));
         wr(2'd0, 32'h2);
         chk("R10 err clear", 64'(sref_err), 64'(0));
      end

      // R10 set beats clear in the same cycle
      wr(2'd0, 32'h1);
      refresh_req = 1'b1; sref_ack = 1'b0;
      sleep_strobe = 1'b1;
      tick();
      sleep_strobe = 1'b0;
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h3;
      tick();
      wr_en = 1'b0; wr_data = '0;
      chk("R10 set wins", 64'(sref_err), 64'(1));
      refresh_req = 1'b0;
      wake_irq = 1'b1; tick(); wake_irq = 1'b0;
      wr(2'd0, 32'h2);
      chk("R10 cleared", 64'(sref_err), 64'(0));

      // R8 wake inputs ignored while running
      wake_irq = 1'b1; wake_rst = 1'b1;
      tick(); tick();
      wake_irq = 1'b0; wake_rst = 1'b0;
      check_run("R8 wake in run");

      // R1 strobe with same-cycle write uses the old deep bit
      wr(2'd0, 32'h0);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h1; sleep_strobe = 1'b1;
      tick();
      wr_en = 1'b0; wr_data = '0; sleep_strobe = 1'b0;
      chk("R1 old deep bit", 64'(status), 64'(2'b01));
      wake_irq = 1'b1; tick(); wake_irq = 1'b0;
      sleep_strobe = 1'b1; tick(); sleep_strobe = 1'b0;
      chk("R1 new deep bit", 64'(status), 64'(2'b10));

      // R11 reset taken from deep sleep
      wr_en = 1'b0;
      rst_n = 1'b0;
      tick();
      chk("R11 status", 64'(status), 64'(0));
      chk("R11 modclk", mod_clk_en, '1);
      rst_n = 1'b1;
      tick();
      sleep_strobe = 1'b1; tick(); sleep_strobe = 1'b0;
      chk("R11 deep bit cleared", 64'(status), 64'(2'b01));

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule